// File: doc/BRIEF.md
# Position-to-Quadrature Encoder Emulator

This block turns a binary angular position word into the three signals of an incremental optical encoder: two quadrature channels and a once-per-revolution index pulse. A motion controller built to count encoder edges can then follow the position source directly, with no change to its own logic. All inputs cross into the block's clock domain through a two-flop synchroniser. The quadrature and index outputs are combinational functions of the synchronised position.

An active-low mode input turns emulation on. When this input falls, the block captures a two-bit resolution select. That select sets which position bit acts as the encoder LSB. It stays fixed until the next entry into the mode, so the same select lines can later change the resolution of the parallel data without disturbing the encoder outputs. One output pin is shared. It carries the normal direction signal outside the mode and carries channel B inside it.

Top module: `qenc_emulator`

## Requirements
- R1: While reset is asserted and after it is released with the mode input high, a_o, b_o and idx_o are 0.
- R2: With the mode input high (emulation off), a_o, b_o and idx_o stay 0 for any position, and dir_b_o follows dir_i.
- R3: Every output responds to an input change after exactly two rising clock edges. No output changes after the first edge alone.
- R4: In emulation, a_o equals position bit L+1. L is the latched LSB, coded by the select as 00→bit 6 (10-bit), 01→bit 4 (12-bit), 10→bit 2 (14-bit), 11→bit 0 (16-bit).
- R5: In emulation, b_o equals position bit L XOR bit L+1, and dir_b_o carries the same value as b_o.
- R6: The select is captured only when the synchronised mode input goes from 1 to 0. Changing the select during emulation has no effect on a_o, b_o or idx_o.
- R7: In emulation, idx_o is 1 exactly when the index enable input is 0 and every position bit from L up to bit 15 is 0. Otherwise idx_o is 0.
- R8: Leaving emulation and entering it again captures the select value present at the new falling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pos_i | input | 16 | Binary angular position |
| emu_n_i | input | 1 | Emulation enable, active low |
| res_sel_i | input | 2 | Resolution select |
| idx_en_n_i | input | 1 | Index pulse enable, active low |
| dir_i | input | 1 | Normal direction signal, passed through outside emulation |
| a_o | output | 1 | Quadrature channel A |
| b_o | output | 1 | Quadrature channel B |
| idx_o | output | 1 | Zero index pulse |
| dir_b_o | output | 1 | Direction outside emulation, channel B inside it |

## Verification
A wrong latched resolution shows up as A and B tracking the wrong position bit pair. It also moves the index window. This appears two edges after the first position change that involves the affected bits. A select change made during emulation must therefore be followed by a position that tells the two resolutions apart. A missed or spurious falling-edge capture appears only at re-entry, so the bench leaves the mode and enters it again with a different select. A synchroniser with the wrong depth shifts every output by one edge. The bench catches this by sampling after one edge and again after two.

// File: rtl/qenc_pkg.sv
package qenc_pkg;
   // default geometry: 16-bit word, four resolutions spaced two bits apart
   localparam int unsigned QE_POS_W    = 16;
   localparam int unsigned QE_NUM_RES  = 4;
   localparam int unsigned QE_RES_STEP = 2;
   localparam int unsigned QE_SYNC_STG = 2;

   // LSB position for a select code: highest code gives the finest resolution
   function automatic int unsigned qe_lsb(int unsigned sel, int unsigned num_res,
                                          int unsigned step);
      return (num_res - 1 - sel) * step;
   endfunction
endpackage

// File: rtl/qenc_sync.sv
module qenc_sync #(
   parameter int unsigned W      = 1,
   parameter int unsigned STAGES = 2,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("qenc_sync needs at least two stages");
      end
   endgenerate

   logic [W-1:0] stg_q [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) stg_q[i] <= RST_VAL;
      end else begin
         stg_q[0] <= d_i;
         for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
      end
   end

   assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/qenc_res_latch.sv
module qenc_res_latch #(
   parameter int unsigned SEL_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             emu_n_s,
   input  logic [SEL_W-1:0] sel_s,
   output logic             active_o,
   output logic [SEL_W-1:0] sel_eff_o
);
   logic             emu_d_q;
   logic [SEL_W-1:0] res_q;
   logic             fall;

   assign fall = emu_d_q & ~emu_n_s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         emu_d_q <= 1'b1;
         res_q   <= '1;            // finest resolution after reset
      end else begin
         emu_d_q <= emu_n_s;
         if (fall) res_q <= sel_s;
      end
   end

   // bypass on the entry cycle so outputs use the new select at once
   assign sel_eff_o = fall ? sel_s : res_q;
   assign active_o  = ~emu_n_s;

   // R6
   hold_res_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !fall |=> res_q == $past(res_q));

   // R8
   capture_res_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fall |=> res_q == $past(sel_s));
endmodule

// File: rtl/qenc_quad_gen.sv
module qenc_quad_gen
   import qenc_pkg::*;
#(
   parameter int unsigned POS_W    = QE_POS_W,
   parameter int unsigned NUM_RES  = QE_NUM_RES,
   parameter int unsigned RES_STEP = QE_RES_STEP,
   localparam int unsigned SEL_W   = $clog2(NUM_RES)
) (
   input  logic [POS_W-1:0] pos_i,
   input  logic [SEL_W-1:0] sel_i,
   input  logic             active_i,
   input  logic             idx_en_i,
   output logic             a_o,
   output logic             b_o,
   output logic             idx_o
);
   logic [NUM_RES-1:0] a_c, b_c, z_c;

   generate
      for (genvar g = 0; g < NUM_RES; g++) begin : g_res
         localparam int unsigned LSB_G = qe_lsb(g, NUM_RES, RES_STEP);
         assign a_c[g] = pos_i[LSB_G+1];
         assign b_c[g] = pos_i[LSB_G] ^ pos_i[LSB_G+1];
         assign z_c[g] = ~|pos_i[POS_W-1:LSB_G];
      end
   endgenerate

   always_comb begin
      a_o   = 1'b0;
      b_o   = 1'b0;
      idx_o = 1'b0;
      if (active_i) begin
         a_o   = a_c[sel_i];
         b_o   = b_c[sel_i];
         idx_o = z_c[sel_i] & idx_en_i;
      end
   end
endmodule

// File: rtl/qenc_emulator.sv
module qenc_emulator
   import qenc_pkg::*;
#(
   parameter int unsigned POS_W     = QE_POS_W,
   parameter int unsigned NUM_RES   = QE_NUM_RES,
   parameter int unsigned RES_STEP  = QE_RES_STEP,
   parameter int unsigned SYNC_STG  = QE_SYNC_STG,
   localparam int unsigned SEL_W    = $clog2(NUM_RES),
   localparam int unsigned BUS_W    = POS_W + SEL_W + 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [POS_W-1:0] pos_i,
   input  logic             emu_n_i,
   input  logic [SEL_W-1:0] res_sel_i,
   input  logic             idx_en_n_i,
   input  logic             dir_i,
   output logic             a_o,
   output logic             b_o,
   output logic             idx_o,
   output logic             dir_b_o
);
   generate
      if (NUM_RES != (1 << SEL_W)) begin : g_bad_num
         $error("NUM_RES must be a power of two");
      end
      if ((NUM_RES - 1) * RES_STEP + 2 > POS_W) begin : g_bad_geom
         $error("coarsest resolution does not fit the position word");
      end
   endgenerate

   localparam logic [BUS_W-1:0] SYNC_RST = {1'b0, 1'b1, 1'b1, {SEL_W{1'b0}}, {POS_W{1'b0}}};

   logic [BUS_W-1:0] raw_bus, syn_bus;
   logic [POS_W-1:0] pos_s;
   logic [SEL_W-1:0] sel_s, sel_eff;
   logic             emu_n_s, idx_en_n_s, dir_s, active;

   assign raw_bus = {dir_i, idx_en_n_i, emu_n_i, res_sel_i, pos_i};
   assign {dir_s, idx_en_n_s, emu_n_s, sel_s, pos_s} = syn_bus;

   qenc_sync #(.W(BUS_W), .STAGES(SYNC_STG), .RST_VAL(SYNC_RST)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (raw_bus),
      .q_o   (syn_bus)
   );

   qenc_res_latch #(.SEL_W(SEL_W)) u_latch (
      .clk       (clk),
      .rst_n     (rst_n),
      .emu_n_s   (emu_n_s),
      .sel_s     (sel_s),
      .active_o  (active),
      .sel_eff_o (sel_eff)
   );

   qenc_quad_gen #(.POS_W(POS_W), .NUM_RES(NUM_RES), .RES_STEP(RES_STEP)) u_quad (
      .pos_i    (pos_s),
      .sel_i    (sel_eff),
      .active_i (active),
      .idx_en_i (~idx_en_n_s),
      .a_o      (a_o),
      .b_o      (b_o),
      .idx_o    (idx_o)
   );

   assign dir_b_o = active ? b_o : dir_s;

   // R2
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !active |-> !a_o && !b_o && !idx_o);

   // R7
   idx_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
      idx_o |-> !a_o && !b_o);

   // R5
   shared_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
      active |-> dir_b_o == b_o);
endmodule

// File: tb/tb_qenc_emulator.sv
module tb_qenc_emulator;
   logic        clk = 1'b0;
   logic        rst_n;
   logic [15:0] pos;
   logic        emu_n, idx_en_n, dir;
   logic [1:0]  sel;
   logic        a, b, idx, dir_b;
   int          checks = 0;
   int          fails  = 0;

   always #5 clk = ~clk;

   qenc_emulator dut (
      .clk(clk), .rst_n(rst_n), .pos_i(pos), .emu_n_i(emu_n), .res_sel_i(sel),
      .idx_en_n_i(idx_en_n), .dir_i(dir), .a_o(a), .b_o(b), .idx_o(idx), .dir_b_o(dir_b)
   );

   // {sel, pos, a, b, idx}; index enabled for all rows
   localparam int NV = 11;
   localparam logic [20:0] VEC [NV] = '{
      {2'd3, 16'h0000, 1'b0, 1'b0, 1'b1},
      {2'd3, 16'h0001, 1'b0, 1'b1, 1'b0},
      {2'd3, 16'h0002, 1'b1, 1'b1, 1'b0},
      {2'd3, 16'h0003, 1'b1, 1'b0, 1'b0},
      {2'd0, 16'h0040, 1'b0, 1'b1, 1'b0},
      {2'd0, 16'h003F, 1'b0, 1'b0, 1'b1},
      {2'd1, 16'h0080, 1'b0, 1'b0, 1'b0},
      {2'd1, 16'h0030, 1'b1, 1'b0, 1'b0},
      {2'd2, 16'h0008, 1'b1, 1'b1, 1'b0},
      {2'd2, 16'h8003, 1'b0, 1'b0, 1'b0},
      {2'd2, 16'h0003, 1'b0, 1'b0, 1'b1}
   };

   task automatic check(input string tag, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
      end
   endtask

   task automatic settle();
      repeat (3) @(negedge clk);
   endtask

   task automatic enter(input logic [1:0] s);
      emu_n = 1'b1;
      settle();
      sel   = s;
      emu_n = 1'b0;
      settle();
   endtask

   initial begin
      #1_000_000;
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      rst_n = 1'b0; pos = 16'hFFFF; emu_n = 1'b1; idx_en_n = 1'b0; dir = 1'b1; sel = 2'd3;
      repeat (3) @(negedge clk);
      // R1 during reset
      check("R1 a in reset", a, 1'b0);
      check("R1 idx in reset", idx, 1'b0);
      rst_n = 1'b1;
      settle();
      check("R1 a after reset", a, 1'b0);
      check("R1 b after reset", b, 1'b0);
      // R2 pass-through while idle
      pos = 16'h0000;
      settle();
      check("R2 idx idle", idx, 1'b0);
      check("R2 dir=1", dir_b, 1'b1);
      dir = 1'b0; pos = 16'h0002;
      settle();
      check("R2 dir=0", dir_b, 1'b0);
      check("R2 a idle", a, 1'b0);

      // table walk: R4, R5, R7
      for (int i = 0; i < NV; i++) begin
         enter(VEC[i][20:19]);
         pos = VEC[i][18:3];
         settle();
         check($sformatf("R4 a vec%0d", i), a, VEC[i][2]);
         check($sformatf("R5 b vec%0d", i), b, VEC[i][1]);
         check($sformatf("R5 dir_b vec%0d", i), dir_b, VEC[i][1]);
         check($sformatf("R7 idx vec%0d", i), idx, VEC[i][0]);
      end

      // R7 index disabled
      enter(2'd3);
      pos = 16'h0000; idx_en_n = 1'b1;
      settle();
      check("R7 idx disabled", idx, 1'b0);
      idx_en_n = 1'b0;
      settle();
      check("R7 idx re-enabled", idx, 1'b1);

      // R6 select change ignored during emulation (16-bit latched)
      pos = 16'h0002;
      settle();
      sel = 2'd0;
      settle();
      check("R6 a after sel change", a, 1'b1);
      check("R6 b after sel change", b, 1'b1);
      pos = 16'h0000;
      settle();
      sel = 2'd1;
      pos = 16'h0020;
      settle();
      check("R6 idx uses latched LSB", idx, 1'b0);

      // R8 re-entry captures new select (10-bit: bit6)
      enter(2'd0);
      pos = 16'h0040;
      settle();
      check("R8 b at re-entry", b, 1'b1);
      check("R8 a at re-entry", a, 1'b0);

      // R3 latency: 16-bit, pos 0 -> 2 makes a rise
      enter(2'd3);
      pos = 16'h0000;
      settle();
      pos = 16'h0002;
      @(posedge clk); @(negedge clk);
      check("R3 a after one edge", a, 1'b0);
      @(posedge clk); @(negedge clk);
      check("R3 a after two edges", a, 1'b1);
      // R3 mode exit latency
      emu_n = 1'b1;
      @(posedge clk); @(negedge clk);
      check("R3 still active after one edge", a, 1'b1);
      @(posedge clk); @(negedge clk);
      check("R3 idle after two edges", a, 1'b0);

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule